// File: doc/BRIEF.md
# Four-Channel DMA Engine with Width Conversion and Chaining

This block moves data between memory and peripherals on four independent channels. Each channel holds a source address, a destination address, a byte count and a mode word. It also holds a second, shadow descriptor that is loaded as soon as the active one runs out. Peripherals signal demand on one request line per channel. A fixed-priority arbiter picks the channel to serve, one transfer unit at a time.

In normal mode a unit is a burst of reads followed by a burst of writes on a simple request/grant master port. An internal buffer packs narrow reads into a wider write, or splits a wide read into narrow writes. In fly-by mode the engine issues only the memory write cycle and asserts the peripheral's acknowledge during it. The data then passes directly from the peripheral to memory and the engine does not buffer it. When a channel finishes its last descriptor, it pulses its own completion interrupt line for one cycle.

Top module: `dma_quad`

## Requirements
- R1: While reset is asserted and after its release with no request pending, `m_req`, every `dack` bit and every `irq` bit are low.
- R2: A pulse on `cfg_we` with `cfg_next` low loads the active source, destination, count and mode of channel `cfg_sel`. The mode bits are: [1:0] source size and [3:2] destination size, each as log2 of bytes (0 = byte, 1 = halfword, 2 = word); [4] source increment; [5] destination increment; [6] fly-by. A normal unit is one or more reads (`m_we` low) followed by one or more writes (`m_we` high). The data is little-endian and right-aligned on the data bus.
- R3: When the source is narrower than the destination, the successive reads of a unit fill the destination word from its lowest byte lane upward.
- R4: When the source is wider than the destination, the unit's read word is written out in narrow pieces, lowest byte first.
- R5: After each accepted beat, an address whose increment bit is set advances by its access size in bytes. An address whose increment bit is clear stays unchanged.
- R6: In fly-by mode each unit is exactly one write cycle at the destination address with `m_flyby` high and no read cycle. `dack` of the served channel is high for that cycle only, and at most one `dack` bit is high at a time.
- R7: The transfer unit is the larger of the two sizes, or the destination size in fly-by mode. The count drops by the unit after each unit. At zero, the channel stops and its `irq` bit pulses high for exactly one cycle, the cycle after the last write is accepted.
- R8: A pulse on `cfg_we` with `cfg_next` high loads the shadow descriptor. When the active count reaches zero with a shadow loaded, the shadow becomes active, no interrupt is raised, and the transfer goes on.
- R9: Among channels whose request is high and whose count is non-zero, the lowest index wins. The choice is re-made after every unit.
- R10: Once `m_req` is raised, it and `m_addr` stay stable until `m_gnt` is sampled high.
- R11: A channel whose request is low, or whose count is zero, causes no bus cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Descriptor write strobe |
| cfg_sel | input | 2 | Channel selected for the write |
| cfg_next | input | 1 | 1 = write the shadow (chained) descriptor |
| cfg_src | input | 32 | Source address |
| cfg_dst | input | 32 | Destination address |
| cfg_cnt | input | 16 | Byte count |
| cfg_mode | input | 7 | Mode word, layout in R2 |
| dreq | input | 4 | Peripheral request per channel |
| dack | output | 4 | Peripheral acknowledge per channel (fly-by) |
| m_req | output | 1 | Bus cycle request |
| m_we | output | 1 | 1 = write cycle |
| m_flyby | output | 1 | Cycle is a fly-by memory cycle |
| m_addr | output | 32 | Byte address |
| m_size | output | 2 | Access size, log2 bytes |
| m_wdata | output | 32 | Write data, right-aligned |
| m_rdata | input | 32 | Read data, right-aligned, valid in the grant cycle |
| m_gnt | input | 1 | Grant; a beat completes when `m_req` and `m_gnt` are both high |
| irq | output | 4 | One-cycle completion pulse per channel |

## Verification
The assertions check these properties on every cycle:
- bus request stability under stalls;
- the single active acknowledge;
- the one-hot arbiter grant and its link to a live request;
- the byte lanes the packing buffer touches;
- counts that never underflow;
- interrupts that fire only on an empty channel.

The bench's scenarios are needed to show the data itself:
- byte order in packing and unpacking;
- address hold and increment;
- a chained second descriptor that produces no extra interrupt;
- the order in which competing channels finish;
- the absence of bus cycles for idle or empty channels.

// File: rtl/dma_pkg.sv
package dma_pkg;
  localparam int DW = 32;
  localparam int MODE_W = 7;

  typedef struct packed {
    logic       flyby;
    logic       dst_inc;
    logic       src_inc;
    logic [1:0] dst_lg;
    logic [1:0] src_lg;
  } mode_t;

  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_RD   = 2'd1,
    S_WR   = 2'd2,
    S_FLY  = 2'd3
  } state_t;
endpackage

// File: rtl/dma_arb.sv
module dma_arb #(
  parameter int N = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req,
  output logic [N-1:0]  gnt,
  output logic [IW-1:0] idx,
  output logic          any
);
  always_comb begin
    gnt = '0;
    idx = '0;
    any = 1'b0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        gnt = '0;
        gnt[i] = 1'b1;
        idx = IW'(i);
        any = 1'b1;
      end
    end
  end

  always_comb begin
    if (!$isunknown(req)) begin
      p_grant_onehot_r9 : assert ($onehot0(gnt) && ((gnt & ~req) == '0));
    end
  end
endmodule

// File: rtl/dma_chan.sv
module dma_chan
  import dma_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld_we,
  input  logic          ld_next,
  input  logic [AW-1:0] ld_src,
  input  logic [AW-1:0] ld_dst,
  input  logic [CW-1:0] ld_cnt,
  input  mode_t         ld_mode,
  input  logic          adv_src,
  input  logic          adv_dst,
  input  logic          unit_done,
  input  logic [1:0]    unit_lg,
  output logic [AW-1:0] src_q,
  output logic [AW-1:0] dst_q,
  output logic [CW-1:0] cnt_q,
  output mode_t         mode_q,
  output logic          busy,
  output logic          done_q
);
  logic [AW-1:0] src_n, dst_n, nsrc_q, nsrc_n, ndst_q, ndst_n;
  logic [CW-1:0] cnt_n, ncnt_q, ncnt_n;
  mode_t         mode_n, nmode_q, nmode_n;
  logic          nv_q, nv_n, done_n;

  assign busy = (cnt_q != '0);

  always_comb begin
    src_n = src_q;  dst_n = dst_q;  cnt_n = cnt_q;  mode_n = mode_q;
    nsrc_n = nsrc_q; ndst_n = ndst_q; ncnt_n = ncnt_q; nmode_n = nmode_q;
    nv_n = nv_q;
    done_n = 1'b0;
    if (adv_src && mode_q.src_inc) src_n = src_q + (AW'(1) << mode_q.src_lg);
    if (adv_dst && mode_q.dst_inc) dst_n = dst_q + (AW'(1) << mode_q.dst_lg);
    if (unit_done) begin
      cnt_n = cnt_q - (CW'(1) << unit_lg);
      if (cnt_n == '0) begin
        if (nv_q) begin
          src_n = nsrc_q; dst_n = ndst_q; cnt_n = ncnt_q; mode_n = nmode_q;
          nv_n = 1'b0;
        end else begin
          done_n = 1'b1;
        end
      end
    end
    if (ld_we) begin
      if (ld_next) begin
        nsrc_n = ld_src; ndst_n = ld_dst; ncnt_n = ld_cnt; nmode_n = ld_mode;
        nv_n = 1'b1;
      end else begin
        src_n = ld_src; dst_n = ld_dst; cnt_n = ld_cnt; mode_n = ld_mode;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q <= '0; dst_q <= '0; cnt_q <= '0; mode_q <= '0;
      nsrc_q <= '0; ndst_q <= '0; ncnt_q <= '0; nmode_q <= '0;
      nv_q <= 1'b0; done_q <= 1'b0;
    end else begin
      src_q <= src_n; dst_q <= dst_n; cnt_q <= cnt_n; mode_q <= mode_n;
      nsrc_q <= nsrc_n; ndst_q <= ndst_n; ncnt_q <= ncnt_n; nmode_q <= nmode_n;
      nv_q <= nv_n; done_q <= done_n;
    end
  end

  p_no_underflow_r7 : assert property (@(posedge clk) disable iff (!rst_n)
    unit_done |-> (cnt_q >= (CW'(1) << unit_lg)));
  p_done_zero_r7 : assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && !$past(ld_we)) |-> (cnt_q == '0));
endmodule

// File: rtl/dma_pack.sv
module dma_pack #(
  parameter int DW = 32,
  localparam int NB = DW / 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_en,
  input  logic [1:0]    rd_beat,
  input  logic [1:0]    src_lg,
  input  logic [DW-1:0] rdata,
  input  logic [1:0]    wr_beat,
  input  logic [1:0]    dst_lg,
  output logic [DW-1:0] wdata
);
  logic [DW-1:0] buf_q, buf_n, shifted;
  int rd_off, wr_off;

  always_comb begin
    buf_n = buf_q;
    rd_off = int'(rd_beat) << src_lg;
    if (rd_en) begin
      for (int b = 0; b < NB; b++) begin
        if (b >= rd_off && b < rd_off + (1 << src_lg))
          buf_n[b*8 +: 8] = rdata[(b - rd_off)*8 +: 8];
      end
    end
  end

  always_comb begin
    wr_off = int'(wr_beat) << dst_lg;
    shifted = buf_q >> (8 * wr_off);
    wdata = '0;
    for (int b = 0; b < NB; b++) begin
      if (b < (1 << dst_lg)) wdata[b*8 +: 8] = shifted[b*8 +: 8];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) buf_q <= '0;
    else if (rd_en) buf_q <= buf_n;
  end

  p_lane_in_range_r3 : assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> ((int'(rd_beat) << src_lg) < NB));
endmodule

// File: rtl/dma_quad.sv
module dma_quad
  import dma_pkg::*;
#(
  parameter int NCH = 4,
  parameter int AW  = 32,
  parameter int CW  = 16,
  localparam int IW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [IW-1:0]     cfg_sel,
  input  logic              cfg_next,
  input  logic [AW-1:0]     cfg_src,
  input  logic [AW-1:0]     cfg_dst,
  input  logic [CW-1:0]     cfg_cnt,
  input  logic [MODE_W-1:0] cfg_mode,
  input  logic [NCH-1:0]    dreq,
  output logic [NCH-1:0]    dack,
  output logic              m_req,
  output logic              m_we,
  output logic              m_flyby,
  output logic [AW-1:0]     m_addr,
  output logic [1:0]        m_size,
  output logic [DW-1:0]     m_wdata,
  input  logic [DW-1:0]     m_rdata,
  input  logic              m_gnt,
  output logic [NCH-1:0]    irq
);
  logic [AW-1:0] src_a [NCH];
  logic [AW-1:0] dst_a [NCH];
  logic [CW-1:0] cnt_a [NCH];
  mode_t         mode_a [NCH];
  logic [NCH-1:0] busy, arb_gnt;
  logic [IW-1:0]  arb_idx, ch_q, ch_n;
  logic           arb_any;
  state_t         state_q, state_n;
  logic [1:0]     beat_q, beat_n, ulg, rd_last, wr_last;
  logic           rd_acc, wr_acc, udone, is_last;
  logic [DW-1:0]  pack_wdata;
  mode_t          cm;

  dma_arb #(.N(NCH)) u_arb (
    .req(dreq & busy), .gnt(arb_gnt), .idx(arb_idx), .any(arb_any)
  );

  assign cm      = mode_a[ch_q];
  assign ulg     = cm.flyby ? cm.dst_lg : ((cm.src_lg > cm.dst_lg) ? cm.src_lg : cm.dst_lg);
  assign rd_last = 2'((3'd1 << (ulg - cm.src_lg)) - 3'd1);
  assign wr_last = 2'((3'd1 << (ulg - cm.dst_lg)) - 3'd1);
  assign rd_acc  = (state_q == S_RD) && m_gnt;
  assign wr_acc  = ((state_q == S_WR) || (state_q == S_FLY)) && m_gnt;
  assign is_last = (state_q == S_FLY) || (beat_q == wr_last);
  assign udone   = wr_acc && is_last;

  generate
    for (genvar i = 0; i < NCH; i++) begin : g_ch
      logic sel;
      assign sel = (ch_q == IW'(i));
      dma_chan #(.AW(AW), .CW(CW)) u_chan (
        .clk(clk), .rst_n(rst_n),
        .ld_we(cfg_we && (cfg_sel == IW'(i))), .ld_next(cfg_next),
        .ld_src(cfg_src), .ld_dst(cfg_dst), .ld_cnt(cfg_cnt), .ld_mode(mode_t'(cfg_mode)),
        .adv_src(rd_acc && sel), .adv_dst(wr_acc && sel),
        .unit_done(udone && sel), .unit_lg(ulg),
        .src_q(src_a[i]), .dst_q(dst_a[i]), .cnt_q(cnt_a[i]), .mode_q(mode_a[i]),
        .busy(busy[i]), .done_q(irq[i])
      );
      assign dack[i] = (state_q == S_FLY) && sel;
    end
  endgenerate

  dma_pack #(.DW(DW)) u_pack (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_acc), .rd_beat(beat_q), .src_lg(cm.src_lg),
    .rdata(m_rdata), .wr_beat(beat_q), .dst_lg(cm.dst_lg), .wdata(pack_wdata)
  );

  always_comb begin
    state_n = state_q;
    ch_n    = ch_q;
    beat_n  = beat_q;
    unique case (state_q)
      S_IDLE: if (arb_any) begin
        ch_n    = arb_idx;
        beat_n  = '0;
        state_n = mode_a[arb_idx].flyby ? S_FLY : S_RD;
      end
      S_RD: if (m_gnt) begin
        if (beat_q == rd_last) begin beat_n = '0; state_n = S_WR; end
        else beat_n = beat_q + 2'd1;
      end
      S_WR: if (m_gnt) begin
        if (is_last) begin beat_n = '0; state_n = S_IDLE; end
        else beat_n = beat_q + 2'd1;
      end
      S_FLY: if (m_gnt) state_n = S_IDLE;
      default: state_n = S_IDLE;
    endcase
  end

  always_comb begin
    m_req   = (state_q != S_IDLE);
    m_we    = (state_q == S_WR) || (state_q == S_FLY);
    m_flyby = (state_q == S_FLY);
    m_addr  = (state_q == S_RD) ? src_a[ch_q] : dst_a[ch_q];
    m_size  = (state_q == S_RD) ? cm.src_lg : cm.dst_lg;
    m_wdata = (state_q == S_WR) ? pack_wdata : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      ch_q    <= '0;
      beat_q  <= '0;
    end else begin
      state_q <= state_n;
      ch_q    <= ch_n;
      beat_q  <= beat_n;
    end
  end

  p_addr_hold_r10 : assert property (@(posedge clk) disable iff (!rst_n)
    (m_req && !m_gnt) |=> (m_req && $stable(m_addr) && $stable(m_we)));
  p_dack_onehot_r6 : assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(dack) && ((dack != '0) -> (m_we && m_flyby)));
endmodule

// File: tb/dma_quad_test.sv
module dma_quad_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we, cfg_next;
  logic [1:0]  cfg_sel;
  logic [31:0] cfg_src, cfg_dst;
  logic [15:0] cfg_cnt;
  logic [6:0]  cfg_mode;
  logic [3:0]  dreq, dack, irq;
  logic        m_req, m_we, m_flyby, m_gnt;
  logic [31:0] m_addr, m_wdata, m_rdata;
  logic [1:0]  m_size;

  int checks = 0, fails = 0, cycles = 0;
  logic stall = 1'b0, tog = 1'b0;
  logic [7:0] mem [256];
  int irq_cnt [4];
  int ord [8];
  int ocnt = 0, req_cyc = 0, rd_cnt = 0, fly_cnt = 0, wcnt = 0;
  logic [7:0] wlog [16];
  logic [31:0] fly_last;

  always #10 clk = ~clk;

  dma_quad uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_next(cfg_next),
    .cfg_src(cfg_src), .cfg_dst(cfg_dst), .cfg_cnt(cfg_cnt), .cfg_mode(cfg_mode),
    .dreq(dreq), .dack(dack), .m_req(m_req), .m_we(m_we), .m_flyby(m_flyby),
    .m_addr(m_addr), .m_size(m_size), .m_wdata(m_wdata), .m_rdata(m_rdata),
    .m_gnt(m_gnt), .irq(irq)
  );

  function automatic logic [7:0] pat(int a);
    return 8'(a * 7 + 8'h5A);
  endfunction

  function automatic logic [31:0] word(int a);
    return {mem[8'(a+3)], mem[8'(a+2)], mem[8'(a+1)], mem[8'(a)]};
  endfunction

  function automatic logic [31:0] pword(int a);
    return {pat(a+3), pat(a+2), pat(a+1), pat(a)};
  endfunction

  always_ff @(posedge clk) tog <= ~tog;
  assign m_gnt = stall ? tog : 1'b1;

  always_comb begin
    m_rdata = word(int'(m_addr[7:0]));
    if (m_size == 2'd0) m_rdata[31:8] = '0;
    else if (m_size == 2'd1) m_rdata[31:16] = '0;
  end

  always @(negedge clk) begin
    cycles++;
    if (rst_n) begin
      for (int i = 0; i < 4; i++) if (irq[i]) begin
        irq_cnt[i]++;
        if (ocnt < 8) ord[ocnt] = i;
        ocnt++;
      end
      if (m_req) req_cyc++;
      if (m_req && m_gnt) begin
        if (!m_we) rd_cnt++;
        else if (m_flyby) begin fly_cnt++; fly_last = m_addr; end
        else begin
          for (int b = 0; b < (1 << m_size); b++) mem[8'(m_addr[7:0] + b)] = m_wdata[b*8 +: 8];
          if (m_addr == 32'hC0) begin
            if (wcnt < 16) wlog[wcnt] = m_wdata[7:0];
            wcnt++;
          end
        end
      end
    end
    if (cycles > 150000) begin
      fails++;
      $display("FAIL watchdog expired: actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cfg(int ch, bit nxt, logic [31:0] s, logic [31:0] d, int n, logic [6:0] md);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = 2'(ch); cfg_next = nxt;
    cfg_src = s; cfg_dst = d; cfg_cnt = 16'(n); cfg_mode = md;
    @(negedge clk);
    cfg_we = 1'b0; cfg_next = 1'b0;
  endtask

  task automatic wait_irq(int ch, int n, string req);
    int t = 0;
    while (irq_cnt[ch] < n && t < 3000) begin @(negedge clk); t++; end
    checks++;
    if (irq_cnt[ch] < n) begin
      fails++;
      $display("FAIL %s: irq%0d count actual=%0d expected=%0d", req, ch, irq_cnt[ch], n);
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R1 m_req", 32'(m_req), 0);
    check("R1 dack/irq", {24'd0, dack, irq}, 0);
  endtask

  task automatic t_word_copy();
    cfg(0, 0, 32'h00, 32'h40, 8, 7'h3A);
    dreq[0] = 1'b1;
    wait_irq(0, 1, "R7 word copy done");
    dreq[0] = 1'b0;
    check("R2 word0", word(32'h40), pword(32'h00));
    check("R5 word1 incremented", word(32'h44), pword(32'h04));
    check("R7 single irq", 32'(irq_cnt[0]), 1);
  endtask

  task automatic t_assemble();
    stall = 1'b1;
    cfg(1, 0, 32'h10, 32'h80, 8, 7'h38);
    dreq[1] = 1'b1;
    wait_irq(1, 1, "R3 assembly done");
    dreq[1] = 1'b0;
    stall = 1'b0;
    check("R3 packed word0", word(32'h80), pword(32'h10));
    check("R3 packed word1", word(32'h84), pword(32'h14));
  endtask

  task automatic t_disassemble();
    wcnt = 0;
    cfg(1, 0, 32'h20, 32'hC0, 8, 7'h12);
    dreq[1] = 1'b1;
    wait_irq(1, 2, "R4 disassembly done");
    dreq[1] = 1'b0;
    check("R5 held dst write count", 32'(wcnt), 8);
    for (int k = 0; k < 8; k++) check("R4 byte order", 32'(wlog[k]), 32'(pat(32'h20 + k)));
  endtask

  task automatic t_src_hold();
    cfg(0, 0, 32'h30, 32'h60, 8, 7'h2A);
    dreq[0] = 1'b1;
    wait_irq(0, 2, "R5 hold done");
    dreq[0] = 1'b0;
    check("R5 held src word0", word(32'h60), pword(32'h30));
    check("R5 held src word1", word(32'h64), pword(32'h30));
  endtask

  task automatic t_flyby();
    rd_cnt = 0; fly_cnt = 0;
    stall = 1'b1;
    cfg(2, 0, 32'h00, 32'hA0, 8, 7'h6A);
    dreq[2] = 1'b1;
    wait_irq(2, 1, "R6 fly-by done");
    dreq[2] = 1'b0;
    stall = 1'b0;
    check("R6 fly-by cycles", 32'(fly_cnt), 2);
    check("R6 no reads", 32'(rd_cnt), 0);
    check("R6 last fly addr", fly_last, 32'hA4);
    check("R6 dack idle", 32'(dack), 0);
  endtask

  task automatic t_chain();
    cfg(3, 0, 32'h08, 32'h48, 4, 7'h3A);
    cfg(3, 1, 32'h0C, 32'h50, 4, 7'h3A);
    dreq[3] = 1'b1;
    wait_irq(3, 1, "R8 chain done");
    repeat (10) @(negedge clk);
    dreq[3] = 1'b0;
    check("R8 first descriptor", word(32'h48), pword(32'h08));
    check("R8 chained descriptor", word(32'h50), pword(32'h0C));
    check("R8 one irq for chain", 32'(irq_cnt[3]), 1);
  endtask

  task automatic t_priority();
    int t = 0;
    ocnt = 0;
    cfg(1, 0, 32'h10, 32'h90, 16, 7'h3A);
    cfg(0, 0, 32'h00, 32'h70, 4, 7'h3A);
    dreq[1] = 1'b1;
    while (!(m_req && m_addr == 32'h10) && t < 100) begin @(negedge clk); t++; end
    dreq[0] = 1'b1;
    wait_irq(1, 3, "R9 preempt run");
    dreq = '0;
    check("R9 ch0 finishes first", 32'(ord[0]), 0);
    check("R9 ch1 finishes second", 32'(ord[1]), 1);
    ocnt = 0;
    cfg(1, 0, 32'h10, 32'h90, 8, 7'h3A);
    cfg(0, 0, 32'h00, 32'h70, 8, 7'h3A);
    @(negedge clk);
    dreq = 4'b0011;
    wait_irq(1, 4, "R9 simultaneous run");
    dreq = '0;
    check("R9 simultaneous order", 32'(ord[0]), 0);
  endtask

  task automatic t_idle();
    cfg(2, 0, 32'h00, 32'hB0, 4, 7'h3A);
    req_cyc = 0;
    repeat (10) @(negedge clk);
    check("R11 no cycle while dreq low", 32'(req_cyc), 0);
    dreq[2] = 1'b1;
    wait_irq(2, 2, "R11 run after dreq");
    req_cyc = 0;
    repeat (10) @(negedge clk);
    check("R11 empty channel ignored", 32'(req_cyc), 0);
    dreq[2] = 1'b0;
    check("R2 copy after idle", word(32'hB0), pword(32'h00));
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = pat(i);
    for (int i = 0; i < 4; i++) irq_cnt[i] = 0;
    rst_n = 1'b0; cfg_we = 1'b0; cfg_next = 1'b0; cfg_sel = '0;
    cfg_src = '0; cfg_dst = '0; cfg_cnt = '0; cfg_mode = '0; dreq = '0;
    repeat (3) @(negedge clk);
    check("R1 in reset", {28'd0, dack}, 0);
    rst_n = 1'b1;
    t_reset();
    t_word_copy();
    t_assemble();
    t_disassemble();
    t_src_hold();
    t_flyby();
    t_chain();
    t_priority();
    t_idle();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule